// File: doc/BRIEF.md
# Presettable Synchronous Down Counter

This block is a counter that steps down by one on every rising clock edge while it is enabled. A single active-low terminal-count output goes low when the count is zero and the enable is low. All control inputs are active-low. The controls are a count enable that also serves as a carry-in, a preset that loads the jam word on the next clock edge, a preset that loads the jam word at once without the clock, and an asynchronous clear that forces the largest count rather than zero.

A parameter selects the number system. In binary mode the register is one plain word. In BCD mode it is a string of 4-bit decimal digits, each running 9 down to 0, where a digit that wraps borrows from the digit above it. Stages chain into a wider divider by feeding the terminal-count output of one stage into the enable of the next. All stages share the same clock.

The block is used as a divide-by-N counter, a programmable interval timer or a loop counter. The present count is driven on an observation port.

Top module: `preset_down_counter`

## Requirements
- R1: With `cnt_en_n` low and no preset or clear active, each rising clock edge lowers the count by one (binary mode: value minus one).
- R2: While `cnt_en_n` is high and no preset or clear is active, the count holds across clock edges.
- R3: `tc_n` is low exactly when the count is zero and `cnt_en_n` is low. It follows `cnt_en_n` without waiting for a clock, so it stays low for the whole clock period in which both conditions hold.
- R4: With `sload_n` low, the next rising edge loads `jam_i`, whatever the state of `cnt_en_n` and even when the count is zero.
- R5: With `aload_n` low, `count_o` takes `jam_i` without a clock edge. While `aload_n` stays low, clock edges, `sload_n` and `cnt_en_n` have no effect.
- R6: With `clear_n` low, `count_o` is forced at once to the largest count (binary 255, BCD 0x99). This overrides every other control, including `aload_n`.
- R7: An enabled edge at count zero with no preset gives the largest count, so a full cycle lasts 256 edges in binary mode and 100 edges in BCD mode.
- R8: In BCD mode, `jam_i[7:4]` is the tens digit and `jam_i[3:0]` is the ones digit. The ones digit wraps from 0 to 9 and takes one from the tens digit (0x10 steps to 0x09).
- R9: When the `tc_n` output of one stage drives the `cnt_en_n` input of a second stage, the pair counts down as one 16-bit value. The pair shows terminal count only when both stages are zero.
- R10: `rst_n` low forces the largest count at once. Its release takes effect after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cnt_en_n | input | 1 | Active-low count enable / carry-in |
| sload_n | input | 1 | Active-low preset, loads on the next clock edge |
| aload_n | input | 1 | Active-low preset that loads immediately |
| clear_n | input | 1 | Active-low asynchronous clear to the largest count |
| jam_i | input | WIDTH | Preset data (binary word or BCD digits) |
| tc_n | output | 1 | Active-low terminal count / carry-out |
| count_o | output | WIDTH | Present count |

## Verification
Terminal count and a clock-edge preset can arrive in the same cycle. The bench drives a stage to zero with the enable low and holds the preset low in that same cycle. It then checks that `tc_n` is low during the cycle and that the following edge loads the jam word instead of wrapping to the largest count. A second collision puts clear, immediate preset, clock-edge preset and enable all active together. Clear must win at once and keep winning across the edges that follow. A behavioural model of all three instances (binary, chained upper stage and BCD) is compared with the outputs on every falling edge.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int DIGIT_W = 4;

  typedef enum logic [1:0] {
    SEL_HOLD,
    SEL_STEP,
    SEL_JAM
  } sel_e;
endpackage

// File: rtl/pdc_rst_sync.sv
module pdc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/pdc_bcd_digit.sv
module pdc_bcd_digit (
  input  logic [3:0] d_i,
  input  logic       borrow_i,
  output logic [3:0] d_o,
  output logic       borrow_o
);
  always_comb begin
    borrow_o = borrow_i && (d_i == 4'd0);
    if (!borrow_i)        d_o = d_i;
    else if (d_i == 4'd0) d_o = 4'd9;
    else                  d_o = d_i - 4'd1;
  end

  always_comb begin
    if (d_i <= 4'd9) begin
      AST_DIGIT_DECIMAL: assert (d_o <= 4'd9); // R8
    end
  end
endmodule

// File: rtl/pdc_dec.sv
module pdc_dec #(
  parameter int WIDTH    = 8,
  parameter bit BCD_MODE = 1'b0
) (
  input  logic [WIDTH-1:0] q_i,
  output logic [WIDTH-1:0] dec_o,
  output logic             zero_o
);
  localparam int DIGITS = WIDTH / pdc_pkg::DIGIT_W;

  if (BCD_MODE) begin : g_bcd
    logic [DIGITS:0] borrow;
    assign borrow[0] = 1'b1;
    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
      pdc_bcd_digit u_digit (
        .d_i      (q_i[g*pdc_pkg::DIGIT_W +: pdc_pkg::DIGIT_W]),
        .borrow_i (borrow[g]),
        .d_o      (dec_o[g*pdc_pkg::DIGIT_W +: pdc_pkg::DIGIT_W]),
        .borrow_o (borrow[g+1])
      );
    end
    assign zero_o = borrow[DIGITS];
  end else begin : g_bin
    assign dec_o  = q_i - {{(WIDTH-1){1'b0}}, 1'b1};
    assign zero_o = (q_i == '0);
  end
endmodule

// File: rtl/pdc_next.sv
module pdc_next #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic [WIDTH-1:0] dec_i,
  input  logic [WIDTH-1:0] jam_i,
  input  logic             sload_n,
  input  logic             cnt_en_n,
  output logic [WIDTH-1:0] nxt_o
);
  pdc_pkg::sel_e sel;

  always_comb begin
    if (!sload_n)       sel = pdc_pkg::SEL_JAM;
    else if (!cnt_en_n) sel = pdc_pkg::SEL_STEP;
    else                sel = pdc_pkg::SEL_HOLD;
  end

  always_comb begin
    unique case (sel)
      pdc_pkg::SEL_JAM:  nxt_o = jam_i;
      pdc_pkg::SEL_STEP: nxt_o = dec_i;
      default:           nxt_o = q_i;
    endcase
  end
endmodule

// File: rtl/preset_down_counter.sv
module preset_down_counter #(
  parameter int WIDTH    = 8,
  parameter bit BCD_MODE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en_n,
  input  logic             sload_n,
  input  logic             aload_n,
  input  logic             clear_n,
  input  logic [WIDTH-1:0] jam_i,
  output logic             tc_n,
  output logic [WIDTH-1:0] count_o
);
  localparam int DIGITS = WIDTH / pdc_pkg::DIGIT_W;

  logic             rst_sync_n;
  logic [WIDTH-1:0] max_val;
  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] count_dec;
  logic [WIDTH-1:0] count_nxt;
  logic             count_zero;

  for (genvar g = 0; g < DIGITS; g++) begin : g_max
    assign max_val[g*pdc_pkg::DIGIT_W +: pdc_pkg::DIGIT_W] = BCD_MODE ? 4'd9 : 4'hF;
  end

  pdc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pdc_dec #(.WIDTH(WIDTH), .BCD_MODE(BCD_MODE)) u_dec (
    .q_i    (count_q),
    .dec_o  (count_dec),
    .zero_o (count_zero)
  );

  pdc_next #(.WIDTH(WIDTH)) u_next (
    .q_i      (count_q),
    .dec_i    (count_dec),
    .jam_i    (jam_i),
    .sload_n  (sload_n),
    .cnt_en_n (cnt_en_n),
    .nxt_o    (count_nxt)
  );

  always_ff @(posedge clk or negedge rst_sync_n or negedge clear_n or negedge aload_n) begin
    if (!rst_sync_n)  count_q <= max_val;
    else if (!clear_n) count_q <= max_val;
    else if (!aload_n) count_q <= jam_i;
    else               count_q <= count_nxt;
  end

  assign tc_n    = ~(count_zero & ~cnt_en_n);
  assign count_o = count_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n || !clear_n || !aload_n)
    (cnt_en_n && sload_n) |=> $stable(count_q)); // R2
  AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n || !clear_n || !aload_n)
    (!sload_n) |=> (count_q == $past(jam_i))); // R4
  AST_WRAP_MAX: assert property (@(posedge clk) disable iff (!rst_sync_n || !clear_n || !aload_n)
    (sload_n && !cnt_en_n && count_q == '0) |=> (count_q == max_val)); // R7
  AST_ALOAD_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n || !clear_n)
    (!aload_n) |-> (count_q == jam_i)); // R5
  AST_CLEAR_MAX: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clear_n) |-> (count_q == max_val)); // R6

  if (!BCD_MODE) begin : g_bin_chk
    AST_BIN_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n || !clear_n || !aload_n)
      (sload_n && !cnt_en_n && count_q != '0) |=> (count_q == $past(count_q) - 1'b1)); // R1
  end
endmodule

// File: tb/preset_down_counter_tb_top.sv
module preset_down_counter_tb_top;
  logic clk = 1'b0;
  logic rst_n, en_n, sload_n, aload_n, clear_n;
  logic [7:0] jam_b, jam_h, jam_d;
  logic [7:0] cnt_lo, cnt_hi, cnt_bcd;
  logic tc_lo, tc_hi, tc_bcd;

  int checks = 0;
  int errors = 0;
  int m_lo = 255, m_hi = 255, m_bcd = 99;
  bit done = 1'b0;

  always #10 clk = ~clk;

  preset_down_counter #(.WIDTH(8), .BCD_MODE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en_n(en_n), .sload_n(sload_n), .aload_n(aload_n),
    .clear_n(clear_n), .jam_i(jam_b), .tc_n(tc_lo), .count_o(cnt_lo));
  preset_down_counter #(.WIDTH(8), .BCD_MODE(1'b0)) dut_hi_i (
    .clk(clk), .rst_n(rst_n), .cnt_en_n(tc_lo), .sload_n(sload_n), .aload_n(aload_n),
    .clear_n(clear_n), .jam_i(jam_h), .tc_n(tc_hi), .count_o(cnt_hi));
  preset_down_counter #(.WIDTH(8), .BCD_MODE(1'b1)) dut_bcd_i (
    .clk(clk), .rst_n(rst_n), .cnt_en_n(en_n), .sload_n(sload_n), .aload_n(aload_n),
    .clear_n(clear_n), .jam_i(jam_d), .tc_n(tc_bcd), .count_o(cnt_bcd));

  function automatic int bcd_val(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int bcd_enc(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: updated at each rising edge
  always @(posedge clk) begin
    if (!rst_n || !clear_n) begin
      m_lo = 255; m_hi = 255; m_bcd = 99;
    end else if (!aload_n || !sload_n) begin
      m_lo = jam_b; m_hi = jam_h; m_bcd = bcd_val(jam_d);
    end else begin
      bit hi_go;
      hi_go = (!en_n && m_lo == 0);
      if (!en_n) begin
        m_lo  = (m_lo == 0) ? 255 : m_lo - 1;
        m_bcd = (m_bcd == 0) ? 99 : m_bcd - 1;
      end
      if (hi_go) m_hi = (m_hi == 0) ? 255 : m_hi - 1;
    end
  end

  function automatic int eff(input int m, input int jam, input int mx);
    if (!rst_n || !clear_n) return mx;
    if (!aload_n) return jam;
    return m;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      int e_lo, e_hi, e_bcd;
      e_lo  = eff(m_lo, jam_b, 255);
      e_hi  = eff(m_hi, jam_h, 255);
      e_bcd = eff(m_bcd, bcd_val(jam_d), 99);
      chk("R1 low stage count", cnt_lo, e_lo);
      chk("R9 upper stage count", cnt_hi, e_hi);
      chk("R8 bcd count", cnt_bcd, bcd_enc(e_bcd));
      chk("R3 low stage tc_n", tc_lo, (!en_n && e_lo == 0) ? 0 : 1);
      chk("R9 upper stage tc_n", tc_hi, (!tc_lo && e_hi == 0) ? 0 : 1);
      chk("R3 bcd tc_n", tc_bcd, (!en_n && e_bcd == 0) ? 0 : 1);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; en_n = 1; sload_n = 1; aload_n = 1; clear_n = 1;
    jam_b = 0; jam_h = 0; jam_d = 0;
    step(3);
    chk("R10 reset low", cnt_lo, 255);
    chk("R10 reset bcd", cnt_bcd, 8'h99);
    rst_n = 1;
    step(3);
    chk("R10 after release", cnt_lo, 255);
    step(4);
    chk("R2 hold disabled", cnt_lo, 255);
    // sync preset while disabled
    jam_b = 8'd5; jam_h = 8'd2; jam_d = 8'h12; sload_n = 0;
    step(1);
    chk("R4 load low", cnt_lo, 5);
    chk("R4 load upper", cnt_hi, 2);
    chk("R8 load bcd digits", cnt_bcd, 8'h12);
    sload_n = 1; en_n = 0;
    step(5);
    chk("R1 count to zero", cnt_lo, 0);
    chk("R3 tc low at zero", tc_lo, 0);
    chk("R9 upper tc high", tc_hi, 1);
    step(1);
    chk("R7 wrap to max", cnt_lo, 255);
    chk("R9 upper stepped", cnt_hi, 1);
    chk("R8 bcd step", cnt_bcd, 8'h06);
    step(6);
    chk("R3 bcd tc at zero", tc_bcd, 0);
    step(1);
    chk("R7 bcd wrap to 99", cnt_bcd, 8'h99);
    // BCD borrow
    jam_d = 8'h10; sload_n = 0;
    step(1);
    chk("R4 load with enable low", cnt_bcd, 8'h10);
    sload_n = 1;
    step(1);
    chk("R8 borrow 10 to 09", cnt_bcd, 8'h09);
    en_n = 1;
    step(3);
    chk("R2 hold mid count", cnt_bcd, 8'h09);
    // zero while disabled, then preset colliding with terminal count
    jam_b = 8'd0; sload_n = 0;
    step(1);
    sload_n = 1;
    #1;
    chk("R3 tc high while disabled", tc_lo, 1);
    jam_b = 8'h40; en_n = 0; sload_n = 0;
    #1;
    chk("R3 tc low without clock", tc_lo, 0);
    step(1);
    chk("R4 preset beats wrap", cnt_lo, 8'h40);
    sload_n = 1;
    step(1);
    chk("R1 step after preset", cnt_lo, 8'h3F);
    // immediate preset
    jam_b = 8'h3C; aload_n = 0;
    #3;
    chk("R5 immediate load", cnt_lo, 8'h3C);
    step(2);
    chk("R5 held over clocks", cnt_lo, 8'h3C);
    aload_n = 1;
    step(1);
    chk("R1 count after release", cnt_lo, 8'h3B);
    // clear beats everything
    sload_n = 0; aload_n = 0; clear_n = 0;
    #3;
    chk("R6 clear immediate", cnt_lo, 255);
    chk("R6 clear bcd", cnt_bcd, 8'h99);
    step(2);
    chk("R6 clear held", cnt_hi, 255);
    clear_n = 1; aload_n = 1; sload_n = 1;
    step(1);
    chk("R1 after clear", cnt_lo, 254);
    // cascade: 0x0103 = 259 edges to zero
    jam_b = 8'd3; jam_h = 8'd1; sload_n = 0;
    step(1);
    sload_n = 1;
    step(259);
    chk("R9 pair at zero low", cnt_lo, 0);
    chk("R9 pair at zero upper", cnt_hi, 0);
    chk("R9 pair tc", tc_hi, 0);
    step(1);
    chk("R9 pair wraps upper", cnt_hi, 255);
    chk("R7 pair wraps low", cnt_lo, 255);
    step(256);
    chk("R7 full binary period", cnt_lo, 255);
    // asynchronous reset mid count
    rst_n = 0;
    #3;
    chk("R10 async reset", cnt_lo, 255);
    en_n = 1;
    step(2);
    rst_n = 1;
    step(3);
    finish_run();
  end
endmodule